// File: doc/BRIEF.md
# Double SHA-256 Nonce Search Engine

This block looks for a proof-of-work nonce. The host loads three things with a one-cycle load strobe: a 256-bit chaining state, which is the result of hashing the first 64-byte chunk of the work; the 96 header bits that still vary; and a starting nonce. The engine then builds each 512-bit second chunk on chip. The chunk is a fixed padding constant with the candidate nonce and the header tail spliced in. The engine compresses that chunk starting from the loaded chaining state. It then compresses the resulting 256-bit digest a second time, starting from the standard SHA-256 initial values.

A single iterative compression core does one round per clock and is shared by both passes. Each candidate therefore costs 132 cycles. After each candidate the nonce advances by one, wrapping at 2^32. When the top word of the final digest is zero, the engine reports that nonce on a held output register together with a one-cycle valid pulse. A new load abandons the candidate in progress and restarts the sweep at once.

Top module: `nonce_search_engine`

## Requirements
- R1: The first-pass message is 32-bit words W0..W15, with Wi at bits [32i+31:32i]. W0..W2 are data_in[31:0], data_in[63:32] and data_in[95:64]. W3 is the candidate nonce, W4 is 32'h80000000, W15 is 32'h00000280 (640), and W5..W14 are zero.
- R2: The first pass starts from midstate_in, with chaining word a in bits [31:0] and word h in bits [255:224]. The second pass starts from the standard SHA-256 initial values. Its message is the 256-bit first digest as W0..W7, then W8 = 32'h80000000, W15 = 32'h00000100, and zeros in between.
- R3: A nonce is golden when bits [255:224] of the second digest are all zero. With midstate 256'h228ea4732a3c9ba860c009cda7252b9161a5e75ec8c582a5f106abb3af41f790 and data 96'h2194261a9395e64dbed17115, nonce 32'h0e33337a is golden and the three nonces just below it are not.
- R4: The cycle after a load strobe, scan_nonce equals the start_nonce that was presented with the strobe.
- R5: After a load, scan_nonce holds each value for exactly 132 cycles and then steps by one. 32'hffffffff steps to 32'h00000000.
- R6: The result for the k-th candidate after a load (k = 0, 1, ...) appears 132*(k+1) cycles after the load edge.
- R7: golden_valid is high for exactly one cycle per golden nonce. In that cycle golden_nonce holds the golden nonce and scan_nonce holds the next one. golden_nonce keeps its value at all other times, including across loads.
- R8: After reset, scan_nonce, golden_nonce and golden_valid are zero, and they stay zero until the first load.
- R9: A load during a sweep discards the candidate in progress. No pulse comes from the old work, and timing restarts from the new load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe that captures new work and restarts the sweep |
| midstate_in | input | 256 | Chaining state left after the first chunk |
| data_in | input | 96 | Varying header tail (merkle tail, time, target bits) |
| start_nonce | input | 32 | First nonce to try after a load |
| scan_nonce | output | 32 | Nonce currently being hashed |
| golden_valid | output | 1 | One-cycle pulse when a golden nonce is found |
| golden_nonce | output | 32 | Most recent golden nonce, held |

## Verification
Each result is due at a fixed cycle count after the load edge. scan_nonce shows the start value one cycle after that edge and steps every 132 cycles after it. The pulse for the k-th candidate arrives exactly 132*(k+1) cycles after the edge. The bench drives and samples on falling edges and counts those edges from each load, so every check lands on the single cycle where the value is due, one cycle before and after where it matters. Each load is timed so that a pulse left over from earlier work would fall inside the window being watched.

// File: rtl/nsearch_pkg.sv
package nsearch_pkg;

    localparam int WORD_W   = 32;
    localparam int STATE_W  = 8 * WORD_W;
    localparam int BLOCK_W  = 16 * WORD_W;
    localparam int TAIL_W   = 3 * WORD_W;
    localparam int ROUNDS   = 64;
    localparam int RND_W    = $clog2(ROUNDS);
    // start + rounds + hand-off, twice per candidate
    localparam int CAND_CYC = 2 * (ROUNDS + 2);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [7:0][WORD_W-1:0]  state_t;
    typedef logic [15:0][WORD_W-1:0] block_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START1,
        PH_RUN1,
        PH_START2,
        PH_RUN2
    } phase_e;

    localparam state_t SHA_IV = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
    };

    localparam logic [0:ROUNDS-1][WORD_W-1:0] ROUND_K = {
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t sum_a(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t sum_e(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t mix_lo(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t mix_hi(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

endpackage

// File: rtl/sha_round_engine.sv
module sha_round_engine
    import nsearch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic [STATE_W-1:0] init_state,
    input  logic [BLOCK_W-1:0] block,
    output logic               done,
    output logic [STATE_W-1:0] digest
);

    typedef struct packed {
        logic             busy;
        logic [RND_W-1:0] rnd;
        logic             done;
        state_t           st;
        state_t           base;
        block_t           w;
        state_t           dig;
    } eng_t;

    eng_t  q, d;
    word_t t1, t2, w_new;
    state_t st_next;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        t1      = '0;
        t2      = '0;
        w_new   = '0;
        st_next = q.st;
        if (abort) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            t1 = q.st[7] + sum_e(q.st[4])
               + ((q.st[4] & q.st[5]) ^ (~q.st[4] & q.st[6]))
               + ROUND_K[q.rnd] + q.w[0];
            t2 = sum_a(q.st[0])
               + ((q.st[0] & q.st[1]) ^ (q.st[0] & q.st[2]) ^ (q.st[1] & q.st[2]));
            st_next[0] = t1 + t2;
            st_next[1] = q.st[0];
            st_next[2] = q.st[1];
            st_next[3] = q.st[2];
            st_next[4] = q.st[3] + t1;
            st_next[5] = q.st[4];
            st_next[6] = q.st[5];
            st_next[7] = q.st[6];
            d.st = st_next;
            w_new = mix_hi(q.w[14]) + q.w[9] + mix_lo(q.w[1]) + q.w[0];
            for (int i = 0; i < 15; i++) begin
                d.w[i] = q.w[i+1];
            end
            d.w[15] = w_new;
            d.rnd   = q.rnd + 1'b1;
            if (q.rnd == RND_W'(ROUNDS - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                for (int i = 0; i < 8; i++) begin
                    d.dig[i] = q.base[i] + st_next[i];
                end
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.rnd  = '0;
            d.st   = state_t'(init_state);
            d.base = state_t'(init_state);
            d.w    = block_t'(block);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign digest = q.dig;

endmodule

// File: rtl/chunk_assembler.sv
module chunk_assembler
    import nsearch_pkg::*;
(
    input  logic [WORD_W-1:0]  nonce,
    input  logic [TAIL_W-1:0]  tail,
    input  logic [STATE_W-1:0] first_digest,
    output logic [BLOCK_W-1:0] block_first,
    output logic [BLOCK_W-1:0] block_second
);

    localparam int FIRST_ZW  = BLOCK_W - TAIL_W - 3 * WORD_W;
    localparam int SECOND_ZW = BLOCK_W - STATE_W - 2 * WORD_W;

    // first chunk: length 640 bits on top, pad marker just above the nonce
    localparam logic [BLOCK_W-TAIL_W-WORD_W-1:0] FIRST_PAD =
        {32'h00000280, {FIRST_ZW{1'b0}}, 32'h80000000};
    // second chunk: length 256 bits on top, pad marker just above the digest
    localparam logic [BLOCK_W-STATE_W-1:0] SECOND_PAD =
        {32'h00000100, {SECOND_ZW{1'b0}}, 32'h80000000};

    assign block_first  = {FIRST_PAD, nonce, tail};
    assign block_second = {SECOND_PAD, first_digest};

endmodule

// File: rtl/nonce_search_engine.sv
module nonce_search_engine
    import nsearch_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [255:0]  midstate_in,
    input  logic [95:0]   data_in,
    input  logic [31:0]   start_nonce,
    output logic [31:0]   scan_nonce,
    output logic          golden_valid,
    output logic [31:0]   golden_nonce
);

    typedef struct packed {
        phase_e              phase;
        logic [WORD_W-1:0]   nonce;
        logic [STATE_W-1:0]  mid;
        logic [TAIL_W-1:0]   tail;
        logic [STATE_W-1:0]  dig1;
        logic                gold_v;
        logic [WORD_W-1:0]   gold_n;
    } ctl_t;

    ctl_t q, d;

    logic               core_start;
    logic               core_done;
    logic [STATE_W-1:0] core_init;
    logic [BLOCK_W-1:0] core_block;
    logic [STATE_W-1:0] core_digest;
    logic [BLOCK_W-1:0] blk_first;
    logic [BLOCK_W-1:0] blk_second;
    logic               hit;

    chunk_assembler u_asm (
        .nonce        (q.nonce),
        .tail         (q.tail),
        .first_digest (q.dig1),
        .block_first  (blk_first),
        .block_second (blk_second)
    );

    sha_round_engine u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (load),
        .start      (core_start),
        .init_state (core_init),
        .block      (core_block),
        .done       (core_done),
        .digest     (core_digest)
    );

    assign hit = (core_digest[STATE_W-1 -: WORD_W] == '0);

    always_comb begin
        core_start = (q.phase == PH_START1) || (q.phase == PH_START2);
        core_init  = (q.phase == PH_START2) ? STATE_W'(SHA_IV) : q.mid;
        core_block = (q.phase == PH_START2) ? blk_second : blk_first;
    end

    always_comb begin
        d        = q;
        d.gold_v = 1'b0;
        unique case (q.phase)
            PH_START1: d.phase = PH_RUN1;
            PH_RUN1: begin
                if (core_done) begin
                    d.dig1  = core_digest;
                    d.phase = PH_START2;
                end
            end
            PH_START2: d.phase = PH_RUN2;
            PH_RUN2: begin
                if (core_done) begin
                    if (hit) begin
                        d.gold_v = 1'b1;
                        d.gold_n = q.nonce;
                    end
                    d.nonce = q.nonce + 1'b1;
                    d.phase = PH_START1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
        if (load) begin
            d.mid    = midstate_in;
            d.tail   = data_in;
            d.nonce  = start_nonce;
            d.phase  = PH_START1;
            d.gold_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign scan_nonce   = q.nonce;
    assign golden_valid = q.gold_v;
    assign golden_nonce = q.gold_n;

endmodule

// File: rtl/nonce_search_checker.sv
module nonce_search_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic [31:0] start_nonce,
    input logic [31:0] scan_nonce,
    input logic        golden_valid,
    input logic [31:0] golden_nonce
);

    // R4
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> scan_nonce == $past(start_nonce));

    // R5
    nonce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && scan_nonce != $past(scan_nonce))
            |-> scan_nonce == $past(scan_nonce) + 32'd1);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        golden_valid |=> !golden_valid);

    // R7
    golden_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !golden_valid |-> $stable(golden_nonce));

    // R7
    golden_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        golden_valid |-> scan_nonce == golden_nonce + 32'd1);

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !golden_valid);

endmodule

bind nonce_search_engine nonce_search_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .start_nonce  (start_nonce),
    .scan_nonce   (scan_nonce),
    .golden_valid (golden_valid),
    .golden_nonce (golden_nonce)
);

// File: tb/tb_nonce_search_engine.sv
`timescale 1ns/1ps
module tb_nonce_search_engine;

    localparam int          CYC   = 132;
    localparam logic [31:0] GOLD  = 32'h0e33337a;
    localparam logic [255:0] VMID =
        256'h228ea4732a3c9ba860c009cda7252b9161a5e75ec8c582a5f106abb3af41f790;
    localparam logic [95:0] VDAT = 96'h2194261a9395e64dbed17115;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [255:0] midstate_in = '0;
    logic [95:0]  data_in = '0;
    logic [31:0]  start_nonce = '0;
    logic [31:0]  scan_nonce;
    logic         golden_valid;
    logic [31:0]  golden_nonce;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nonce_search_engine dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .midstate_in  (midstate_in),
        .data_in      (data_in),
        .start_nonce  (start_nonce),
        .scan_nonce   (scan_nonce),
        .golden_valid (golden_valid),
        .golden_nonce (golden_nonce)
    );

    function automatic logic [31:0] nonce_after(input logic [31:0] s, input int k);
        return s + 32'(k);
    endfunction

    function automatic int pulse_at(input int k);
        return CYC * (k + 1);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic do_load(input logic [255:0] m, input logic [95:0] dt,
                           input logic [31:0] s);
        @(negedge clk);
        load = 1'b1; midstate_in = m; data_in = dt; start_nonce = s;
        @(negedge clk);
        load = 1'b0; midstate_in = $urandom; data_in = {$urandom, $urandom, $urandom};
        start_nonce = $urandom;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic watch(input int n, output int first_at, output int cnt,
                         output logic [31:0] got);
        first_at = -1; cnt = 0; got = '0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (golden_valid) begin
                cnt++;
                if (first_at < 0) begin
                    first_at = i;
                    got = golden_nonce;
                end
            end
        end
    endtask

    initial begin
        #(100000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int          fa, cnt;
        logic [31:0] got, s;
        void'($urandom(32'd20240611));

        // R8 reset state
        wait_n(3);
        check("R8", "scan_nonce in reset", scan_nonce, 32'd0);
        rst_n = 1'b1;
        watch(20, fa, cnt, got);
        check("R8", "pulses before load", 32'(cnt), 32'd0);
        check("R8", "golden_valid idle", {31'd0, golden_valid}, 32'd0);
        check("R8", "golden_nonce idle", golden_nonce, 32'd0);
        check("R8", "scan_nonce idle", scan_nonce, 32'd0);

        // R1 R2 R3 golden vector, starting three below
        do_load(VMID, VDAT, GOLD - 32'd3);
        check("R4", "scan after load", scan_nonce, GOLD - 32'd3);
        wait_n(CYC - 1);
        check("R5", "scan held one period", scan_nonce, GOLD - 32'd3);
        wait_n(1);
        check("R5", "scan after one period", scan_nonce, nonce_after(GOLD - 32'd3, 1));
        watch(pulse_at(3) - CYC + 2, fa, cnt, got);
        check("R6", "golden pulse cycle", 32'(fa + CYC), 32'(pulse_at(3)));
        check("R3", "golden pulse count", 32'(cnt), 32'd1);
        check("R1", "golden nonce value", got, GOLD);
        check("R7", "pulse ended", {31'd0, golden_valid}, 32'd0);
        check("R7", "golden_nonce held", golden_nonce, GOLD);
        check("R7", "scan past golden", scan_nonce, GOLD + 32'd1);

        // R6 start exactly on the golden nonce
        do_load(VMID, VDAT, GOLD);
        check("R7", "golden_nonce across load", golden_nonce, GOLD);
        watch(pulse_at(0) + 3, fa, cnt, got);
        check("R6", "immediate pulse cycle", 32'(fa), 32'(pulse_at(0)));
        check("R2", "immediate pulse nonce", got, GOLD);

        // R9 reload mid-sweep: old work would pulse at 396 after first load
        do_load(VMID, VDAT, GOLD - 32'd2);
        watch(200, fa, cnt, got);
        check("R9", "no pulse before reload", 32'(cnt), 32'd0);
        do_load(VMID, VDAT, GOLD - 32'd1);
        check("R9", "scan after reload", scan_nonce, GOLD - 32'd1);
        watch(pulse_at(1) + 4, fa, cnt, got);
        check("R9", "pulse timed from reload", 32'(fa), 32'(pulse_at(1)));
        check("R9", "single pulse after reload", 32'(cnt), 32'd1);

        // R5 wrap at 2^32
        do_load({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom}, 32'hffffffff);
        wait_n(CYC);
        check("R5", "wrap to zero", scan_nonce, nonce_after(32'hffffffff, 1));
        wait_n(CYC);
        check("R5", "step after wrap", scan_nonce, 32'd1);

        // R4 R5 random work and starting points
        for (int t = 0; t < 6; t++) begin
            s = $urandom;
            do_load({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom}, s);
            check("R4", "random start", scan_nonce, s);
            wait_n(CYC - 1);
            check("R5", "random hold", scan_nonce, s);
            wait_n(CYC + 1);
            check("R5", "random two steps", scan_nonce, nonce_after(s, 2));
        end

        finish_run();
    end

endmodule